// File: doc/BRIEF.md
# LIN Transmit Path Safety Gate

This block sits in the transmit path of a LIN physical-layer interface. It sits between the controller's transmit-data line and the enable of the bus driver. The transmit line is active-low: low asks for a dominant bit and high asks for a recessive bit. The block passes a dominant request on to the driver only while the interface is in normal mode and no safety condition holds the bus released. When the bus is released, the driver stays off and the bus rests recessive.

Three independent release conditions exist, and each has its own re-arm rule:

- **Dominant timeout.** A stuck-low transmit line is cut off after a programmable number of clock ticks. It re-arms only after the line is seen high.
- **Thermal fault.** An over-temperature flag releases the bus in the same cycle it is seen. After the flag drops, the block also waits for the line to be seen high before it re-arms. This waiting avoids thermal oscillation.
- **Supply monitor.** A battery monitor with two comparator flags gives hysteresis. The low flag blocks the driver and only the high flag releases it.

A supply block does not alter the operating mode. Reception is untouched by this block. Three status outputs report the reason for each release separately.

The default timeout is 2,500,000 ticks, which is 25 ms at 100 MHz. This sits inside the 15–50 ms window. It is long enough that legitimate dominant runs at 1 kbps are never cut.

Top module: `lin_tx_gate`

## Requirements
- R1: In normal mode with no active block, `drive_dom_o` is high in the same cycle that `txd_i` is low and low in the same cycle that `txd_i` is high.
- R2: While `normal_i` is low, `drive_dom_o` is low regardless of `txd_i`.
- R3: After `txd_i` has been sampled low on TIMEOUT_TICKS consecutive rising clock edges in normal mode, `timeout_active_o` goes high and `drive_dom_o` goes low. After one edge fewer, the driver is still enabled.
- R4: The dominant timeout stays asserted while `txd_i` stays low, with the counter saturating rather than wrapping. It clears at the first rising edge at which `txd_i` is sampled high. Any high sample restarts the count from zero.
- R5: While `thermal_i` is high, `thermal_block_o` is high and `drive_dom_o` is low, in the same cycle.
- R6: After `thermal_i` falls, `thermal_block_o` stays high and the driver stays off until a rising edge at which `txd_i` is sampled high. The block clears after that edge.
- R7: `battery_block_o` is set at the first edge at which `batt_low_i` is sampled high. It clears only at an edge where `batt_high_i` is high and `batt_low_i` is low, and the low flag wins when both are high. While it is set, `drive_dom_o` is low.
- R8: An edge with `normal_i` low clears the dominant timeout and the latched thermal block. `battery_block_o` keeps its value and keeps following the monitor flags in any mode.
- R9: After reset, all status outputs are low and the timeout count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txd_i | input | 1 | Transmit data from the controller; low requests dominant |
| normal_i | input | 1 | High while the interface is in normal mode |
| thermal_i | input | 1 | Over-temperature flag |
| batt_low_i | input | 1 | Supply below the falling threshold |
| batt_high_i | input | 1 | Supply above the rising threshold |
| drive_dom_o | output | 1 | Driver pulls the bus dominant when high |
| timeout_active_o | output | 1 | Dominant timeout is releasing the bus |
| thermal_block_o | output | 1 | Thermal fault or pending thermal re-arm |
| battery_block_o | output | 1 | Supply monitor is blocking the driver |

## Verification
The assertions assume that all inputs are synchronous to `clk_i` and already free of glitches. They also assume that the two supply flags come from an ordered comparator pair, so that low-with-high appears only as a short overlap.

The stimulus changes every input on the falling clock edge. It holds each value across at least one rising edge. It drives both supply flags together only in the one priority case that R7 names.

The timeout is shortened to a small parameter value so that the saturation and restart cases finish in a few dozen cycles.

// File: rtl/lin_gate_pkg.sv
package lin_gate_pkg;
  typedef struct packed {
    logic timeout;
    logic thermal;
    logic battery;
  } gate_status_t;

  localparam int unsigned DefaultTimeoutTicks = 2500000;
endpackage

// File: rtl/lin_dom_timeout.sv
module lin_dom_timeout #(
  parameter int unsigned TIMEOUT_TICKS = 2500000,
  localparam int unsigned CntW = $clog2(TIMEOUT_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic normal_i,
  output logic timeout_o
);
  localparam logic [CntW-1:0] Limit = CntW'(TIMEOUT_TICKS);

  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!normal_i || txd_i) begin
      cnt_q <= '0;
    end else if (cnt_q != Limit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign timeout_o = (cnt_q == Limit);

  assert_timeout_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && !txd_i && normal_i |=> timeout_o);
  assert_timeout_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_i |=> !timeout_o);
endmodule

// File: rtl/lin_thermal_latch.sv
module lin_thermal_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic normal_i,
  input  logic thermal_i,
  output logic block_o
);
  logic hold_q;

  // set by the flag, cleared only by a high TxD once the flag is gone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
    end else if (!normal_i) begin
      hold_q <= 1'b0;
    end else if (thermal_i) begin
      hold_q <= 1'b1;
    end else if (txd_i) begin
      hold_q <= 1'b0;
    end
  end

  assign block_o = thermal_i | hold_q;

  assert_thermal_latches_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    normal_i && thermal_i |=> block_o);
  assert_thermal_needs_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o && normal_i && !txd_i |=> block_o);
endmodule

// File: rtl/lin_batt_hyst.sv
module lin_batt_hyst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic batt_low_i,
  input  logic batt_high_i,
  output logic block_o
);
  logic block_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      block_q <= 1'b0;
    end else if (batt_low_i) begin
      block_q <= 1'b1;
    end else if (batt_high_i) begin
      block_q <= 1'b0;
    end
  end

  assign block_o = block_q;

  assert_batt_low_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batt_low_i |=> block_o);
  assert_batt_high_releases_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !batt_low_i && batt_high_i |=> !block_o);
  assert_batt_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !batt_low_i && !batt_high_i |=> $stable(block_o));
endmodule

// File: rtl/lin_tx_gate.sv
module lin_tx_gate
  import lin_gate_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = DefaultTimeoutTicks
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic normal_i,
  input  logic thermal_i,
  input  logic batt_low_i,
  input  logic batt_high_i,
  output logic drive_dom_o,
  output logic timeout_active_o,
  output logic thermal_block_o,
  output logic battery_block_o
);
  gate_status_t st;

  lin_dom_timeout #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timeout (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .txd_i    (txd_i),
    .normal_i (normal_i),
    .timeout_o(st.timeout)
  );

  lin_thermal_latch u_thermal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .txd_i    (txd_i),
    .normal_i (normal_i),
    .thermal_i(thermal_i),
    .block_o  (st.thermal)
  );

  lin_batt_hyst u_batt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .batt_low_i (batt_low_i),
    .batt_high_i(batt_high_i),
    .block_o    (st.battery)
  );

  assign drive_dom_o      = normal_i && !txd_i && (st == '0);
  assign timeout_active_o = st.timeout;
  assign thermal_block_o  = st.thermal;
  assign battery_block_o  = st.battery;

  assert_drive_needs_normal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_dom_o |-> normal_i);
  assert_timeout_releases_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_active_o |-> !drive_dom_o);
  assert_thermal_releases_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thermal_i |-> !drive_dom_o && thermal_block_o);
  assert_mode_exit_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !normal_i |=> !timeout_active_o);
endmodule

// File: tb/lin_tx_gate_tb.sv
module lin_tx_gate_tb;
  localparam int unsigned TMO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1, normal = 1'b0, thermal = 1'b0, blow = 1'b0, bhigh = 1'b0;
  logic drive, tout, tblk, bblk;
  int   n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  lin_tx_gate #(.TIMEOUT_TICKS(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .txd_i(txd), .normal_i(normal),
    .thermal_i(thermal), .batt_low_i(blow), .batt_high_i(bhigh),
    .drive_dom_o(drive), .timeout_active_o(tout),
    .thermal_block_o(tblk), .battery_block_o(bblk)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // advance n rising edges, return just after the next falling edge
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R9 timeout", tout, 1'b0);
    chk("R9 thermal", tblk, 1'b0);
    chk("R9 battery", bblk, 1'b0);
    chk("R9 drive", drive, 1'b0);
  endtask

  task automatic t_pass();
    normal = 1'b1; txd = 1'b0; #1;
    chk("R1 low drives", drive, 1'b1);
    @(negedge clk); txd = 1'b1; #1;
    chk("R1 high releases", drive, 1'b0);
    @(negedge clk); txd = 1'b0; #1;
    chk("R1 low again", drive, 1'b1);
    edges(1); txd = 1'b1; edges(1);
  endtask

  task automatic t_not_normal();
    normal = 1'b0; txd = 1'b0; #1;
    chk("R2 idle low", drive, 1'b0);
    edges(3); #1;
    chk("R2 idle held", drive, 1'b0);
    txd = 1'b1; normal = 1'b1; edges(1);
  endtask

  task automatic t_timeout();
    txd = 1'b0;
    edges(TMO - 1); #1;
    chk("R3 before limit", drive, 1'b1);
    chk("R3 flag before", tout, 1'b0);
    edges(1); #1;
    chk("R3 at limit drive", drive, 1'b0);
    chk("R3 at limit flag", tout, 1'b1);
    edges(TMO + 5); #1;
    chk("R4 saturates", tout, 1'b1);
    chk("R4 still off", drive, 1'b0);
    txd = 1'b1; #1;
    chk("R4 flag until edge", tout, 1'b1);
    edges(1); #1;
    chk("R4 cleared", tout, 1'b0);
    txd = 1'b0; #1;
    chk("R4 resumes", drive, 1'b1);
    edges(TMO - 2); txd = 1'b1; edges(1); txd = 1'b0;
    edges(TMO - 1); #1;
    chk("R4 restart count", drive, 1'b1);
    txd = 1'b1; edges(1);
  endtask

  task automatic t_thermal();
    txd = 1'b0; #1;
    chk("R5 pre", drive, 1'b1);
    thermal = 1'b1; #1;
    chk("R5 same cycle drive", drive, 1'b0);
    chk("R5 same cycle flag", tblk, 1'b1);
    edges(2); thermal = 1'b0; edges(3); #1;
    chk("R6 latched", tblk, 1'b1);
    chk("R6 drive off", drive, 1'b0);
    txd = 1'b1; #1;
    chk("R6 until edge", tblk, 1'b1);
    edges(1); #1;
    chk("R6 cleared", tblk, 1'b0);
    txd = 1'b0; #1;
    chk("R6 resumes", drive, 1'b1);
    txd = 1'b1; edges(1);
  endtask

  task automatic t_battery();
    blow = 1'b1; edges(1); blow = 1'b0; #1;
    chk("R7 set", bblk, 1'b1);
    txd = 1'b0; #1;
    chk("R7 drive off", drive, 1'b0);
    txd = 1'b1;
    edges(3); #1;
    chk("R7 holds", bblk, 1'b1);
    blow = 1'b1; bhigh = 1'b1; edges(1); #1;
    chk("R7 low wins", bblk, 1'b1);
    blow = 1'b0; edges(1); #1;
    chk("R7 released", bblk, 1'b0);
    bhigh = 1'b0;
    blow = 1'b1; edges(1); blow = 1'b0;
    normal = 1'b0; edges(2); #1;
    chk("R8 battery kept", bblk, 1'b1);
    bhigh = 1'b1; edges(1); #1;
    chk("R8 battery tracks", bblk, 1'b0);
    bhigh = 1'b0; normal = 1'b1; edges(1);
  endtask

  task automatic t_mode_exit();
    txd = 1'b0; edges(TMO); #1;
    chk("R8 timeout set", tout, 1'b1);
    normal = 1'b0; edges(1); #1;
    chk("R8 timeout cleared", tout, 1'b0);
    normal = 1'b1; #1;
    chk("R8 drive after reentry", drive, 1'b1);
    thermal = 1'b1; edges(1); thermal = 1'b0; edges(1); #1;
    chk("R8 thermal latched", tblk, 1'b1);
    normal = 1'b0; edges(1); normal = 1'b1; #1;
    chk("R8 thermal cleared", tblk, 1'b0);
    chk("R8 thermal drive", drive, 1'b1);
    txd = 1'b1; edges(1);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    edges(2);
    t_reset();
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_pass();
    t_not_normal();
    t_timeout();
    t_thermal();
    t_battery();
    t_mode_exit();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule